// File: doc/BRIEF.md
# Slow-Control Command Decoder with Time Stamp Counter

This block sits in the configuration path of a pixel readout chip. It takes slow-control commands as parallel words (an 8-bit opcode and a 16-bit argument, qualified by a valid strobe). Internally it runs a 48-bit time stamp counter. It also records the counter value at each rising and each falling edge of an asynchronous shutter input.

Each accepted command is answered with 48-bit reply words. Each word has an 8-bit header and a 40-bit body. A read command gives a data word followed by a closing word. A write command gives an acknowledgement followed by the same closing word. An opcode the block does not know gives a single error word. Every control word (acknowledge, closing, error) carries the opcode that caused it and a fixed 32-bit chip identifier.

Replies leave through a valid/ready port, one word per accepted cycle. A new command is taken only once every reply of the previous one has gone out.

Top module: `sc_cmd_timer`

## Requirements
- R1: Opcode 0x40 sets the counter to zero on the accepting clock edge, and is answered with an acknowledge word (header 0x70) and then a closing word (header 0x71).
- R2: Whenever the counter is not written by a command, it advances by one on every clock edge and wraps from 2^48-1 to 0.
- R3: Opcodes 0x41, 0x42 and 0x43 write the argument into counter bits [15:0], [31:16] and [47:32] respectively. On that edge the other counter bits keep their previous value and do not advance.
- R4: Opcode 0x44 returns a word with header 0x44 and body {8'h00, counter[31:0]}. Opcode 0x45 returns header 0x45 and body {24'h0, counter[47:32]}. Both use the counter value held just before the accepting edge.
- R5: The shutter passes through two synchronising flops. On a rise, the capture register takes the counter value held just after the second edge that samples the shutter high. Opcodes 0x46/0x47 read that value, split into low and high parts in the same layout as R4.
- R6: On a shutter fall, a second capture register is loaded in the same way. Opcodes 0x48/0x49 read it. Each capture register keeps its value until the next edge of its own kind.
- R7: Every read word is followed by a closing word with header 0x71, body bits [39:32] equal to the opcode, and bits [31:0] equal to the CHIP_ID parameter.
- R8: Write opcodes (0x40 to 0x43) produce an acknowledge word (header 0x70, same echo and identifier layout as R7) and then the closing word.
- R9: Any other opcode produces exactly one word: header 0x73, opcode in [39:32], identifier in [31:0]. It leaves the counter running as in R2.
- R10: rsp_word stays unchanged while rsp_valid is high and rsp_ready is low. cmd_ready is high only when no reply is pending. Replies come out in the order stated above.
- R11: After reset rsp_valid is low, cmd_ready is high, the counter starts at zero and both capture registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_hdr | input | 8 | Command opcode |
| cmd_arg | input | 16 | Command argument |
| shutter | input | 1 | Asynchronous shutter level |
| rsp_valid | output | 1 | Reply word present |
| rsp_ready | input | 1 | Receiver takes the reply word |
| rsp_word | output | 48 | Reply word, header in [47:40] |

## Verification
The bench writes all three counter slices with 0xFFFF and reads the counter back. A design that carries wrongly across the 48-bit boundary, or that lets the untouched slices advance on the write edge, returns a value one off in the upper part. Shutter pulses as short as one cycle are generated, and the captures are checked against the exact synchroniser latency. A capture taken one stage early or late shows up as an off-by-one stamp. Unknown opcodes at both ends of the byte range, and long stretches with rsp_ready held low, would expose a stray closing word, a word that changes under back-pressure, or a command taken while replies are still pending.

// File: rtl/sccmd_pkg.sv
package sccmd_pkg;

    localparam int HDR_W  = 8;
    localparam int ARG_W  = 16;
    localparam int BODY_W = 40;
    localparam int PKT_W  = HDR_W + BODY_W;
    localparam int TIME_W = 48;
    localparam int ID_W   = 32;
    localparam int NSLICE = TIME_W / ARG_W;

    // opcodes taken in
    localparam logic [HDR_W-1:0] OP_TCLR     = 8'h40;
    localparam logic [HDR_W-1:0] OP_TSET0    = 8'h41;
    localparam logic [HDR_W-1:0] OP_TSET1    = 8'h42;
    localparam logic [HDR_W-1:0] OP_TSET2    = 8'h43;
    localparam logic [HDR_W-1:0] OP_RD_LO    = 8'h44;
    localparam logic [HDR_W-1:0] OP_RD_HI    = 8'h45;
    localparam logic [HDR_W-1:0] OP_RISE_LO  = 8'h46;
    localparam logic [HDR_W-1:0] OP_RISE_HI  = 8'h47;
    localparam logic [HDR_W-1:0] OP_FALL_LO  = 8'h48;
    localparam logic [HDR_W-1:0] OP_FALL_HI  = 8'h49;

    // reply headers
    localparam logic [HDR_W-1:0] PK_ACK = 8'h70;
    localparam logic [HDR_W-1:0] PK_EOC = 8'h71;
    localparam logic [HDR_W-1:0] PK_BAD = 8'h73;

    typedef struct packed {
        logic [HDR_W-1:0]  hdr;
        logic [BODY_W-1:0] body;
    } pkt_t;

    typedef enum logic [1:0] {
        TACT_RUN = 2'd0,
        TACT_CLR = 2'd1,
        TACT_SET = 2'd2
    } tact_e;

    typedef struct packed {
        tact_e            act;
        logic [1:0]       slice;
        logic [ARG_W-1:0] arg;
    } tcmd_t;

    function automatic pkt_t ctl_pkt(input logic [HDR_W-1:0] h,
                                     input logic [HDR_W-1:0] echo,
                                     input logic [ID_W-1:0]  id);
        pkt_t p;
        p.hdr  = h;
        p.body = {echo, id};
        return p;
    endfunction

    function automatic logic [BODY_W-1:0] lo_body(input logic [TIME_W-1:0] t);
        return {{(BODY_W-32){1'b0}}, t[31:0]};
    endfunction

    function automatic logic [BODY_W-1:0] hi_body(input logic [TIME_W-1:0] t);
        return {{(BODY_W-(TIME_W-32)){1'b0}}, t[TIME_W-1:32]};
    endfunction

endpackage

// File: rtl/sc_timer.sv
module sc_timer
    import sccmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tcmd_t             cmd,
    output logic [TIME_W-1:0] value
);

    logic [TIME_W-1:0] nxt;

    always_comb begin
        nxt = value + TIME_W'(1);
        case (cmd.act)
            TACT_CLR: nxt = '0;
            TACT_SET: begin
                nxt = value;
                for (int k = 0; k < NSLICE; k++) begin
                    if (cmd.slice == 2'(k)) nxt[k*ARG_W +: ARG_W] = cmd.arg;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= nxt;
    end

endmodule

// File: rtl/sc_shutter_stamp.sv
module sc_shutter_stamp
    import sccmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         shutter,
    input  logic [TIME_W-1:0]            time_now,
    output logic [1:0][TIME_W-1:0]       stamps
);

    // chain[SYNC_STAGES-1] is the synchronised level, chain[SYNC_STAGES] its delayed copy
    logic [SYNC_STAGES:0] chain;
    logic [1:0]           edge_hit;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], shutter};
    end

    assign edge_hit[0] =  chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign edge_hit[1] = ~chain[SYNC_STAGES-1] &  chain[SYNC_STAGES];

    for (genvar g = 0; g < 2; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (rst)              stamps[g] <= '0;
            else if (edge_hit[g]) stamps[g] <= time_now;
        end
    end

endmodule

// File: rtl/sc_decode.sv
module sc_decode
    import sccmd_pkg::*;
#(
    parameter logic [ID_W-1:0] CHIP_ID = 32'hC0DE_0A17
)(
    input  logic [HDR_W-1:0]        hdr,
    input  logic [ARG_W-1:0]        arg,
    input  logic [TIME_W-1:0]       time_now,
    input  logic [1:0][TIME_W-1:0]  stamps,
    output pkt_t                    first,
    output pkt_t                    second,
    output logic                    two,
    output tcmd_t                   tcmd
);

    always_comb begin
        tcmd.act   = TACT_RUN;
        tcmd.slice = 2'd0;
        tcmd.arg   = arg;
        first      = ctl_pkt(PK_BAD, hdr, CHIP_ID);
        second     = ctl_pkt(PK_EOC, hdr, CHIP_ID);
        two        = 1'b1;
        case (hdr)
            OP_TCLR: begin
                tcmd.act = TACT_CLR;
                first    = ctl_pkt(PK_ACK, hdr, CHIP_ID);
            end
            OP_TSET0, OP_TSET1, OP_TSET2: begin
                tcmd.act   = TACT_SET;
                tcmd.slice = 2'(hdr - OP_TSET0);
                first      = ctl_pkt(PK_ACK, hdr, CHIP_ID);
            end
            OP_RD_LO:   first = '{hdr: hdr, body: lo_body(time_now)};
            OP_RD_HI:   first = '{hdr: hdr, body: hi_body(time_now)};
            OP_RISE_LO: first = '{hdr: hdr, body: lo_body(stamps[0])};
            OP_RISE_HI: first = '{hdr: hdr, body: hi_body(stamps[0])};
            OP_FALL_LO: first = '{hdr: hdr, body: lo_body(stamps[1])};
            OP_FALL_HI: first = '{hdr: hdr, body: hi_body(stamps[1])};
            default:    two   = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_reply_queue.sv
module sc_reply_queue
    import sccmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  pkt_t in0,
    input  pkt_t in1,
    input  logic in_two,
    output pkt_t out_pkt,
    output logic out_valid,
    input  logic out_ready,
    output logic empty
);

    pkt_t       slot0, slot1;
    logic [1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot0 <= '0;
            slot1 <= '0;
            cnt   <= 2'd0;
        end else if (load) begin
            slot0 <= in0;
            slot1 <= in1;
            cnt   <= in_two ? 2'd2 : 2'd1;
        end else if (out_valid && out_ready) begin
            slot0 <= slot1;
            cnt   <= cnt - 2'd1;
        end
    end

    assign out_pkt   = slot0;
    assign out_valid = (cnt != 2'd0);
    assign empty     = (cnt == 2'd0);

endmodule

// File: rtl/sc_cmd_timer.sv
module sc_cmd_timer
    import sccmd_pkg::*;
#(
    parameter logic [31:0] CHIP_ID     = 32'hC0DE_0A17,
    parameter int          SYNC_STAGES = 2
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [7:0]  cmd_hdr,
    input  logic [15:0] cmd_arg,
    input  logic        shutter,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [47:0] rsp_word
);

    logic [TIME_W-1:0]       timer_now;
    logic [1:0][TIME_W-1:0]  stamps;
    pkt_t                    dec_first, dec_second, q_out;
    logic                    dec_two, fire, q_empty;
    tcmd_t                   dec_tcmd, tcmd_eff;

    assign fire = cmd_valid && cmd_ready;

    always_comb begin
        tcmd_eff = dec_tcmd;
        if (!fire) tcmd_eff.act = TACT_RUN;
    end

    sc_timer i_timer (
        .clk   (clk),
        .rst   (rst),
        .cmd   (tcmd_eff),
        .value (timer_now)
    );

    sc_shutter_stamp #(.SYNC_STAGES(SYNC_STAGES)) i_stamp (
        .clk      (clk),
        .rst      (rst),
        .shutter  (shutter),
        .time_now (timer_now),
        .stamps   (stamps)
    );

    sc_decode #(.CHIP_ID(CHIP_ID)) i_decode (
        .hdr      (cmd_hdr),
        .arg      (cmd_arg),
        .time_now (timer_now),
        .stamps   (stamps),
        .first    (dec_first),
        .second   (dec_second),
        .two      (dec_two),
        .tcmd     (dec_tcmd)
    );

    sc_reply_queue i_queue (
        .clk       (clk),
        .rst       (rst),
        .load      (fire),
        .in0       (dec_first),
        .in1       (dec_second),
        .in_two    (dec_two),
        .out_pkt   (q_out),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .empty     (q_empty)
    );

    assign cmd_ready = q_empty;
    assign rsp_word  = q_out;

endmodule

// File: rtl/sc_cmd_timer_chk.sv
module sc_cmd_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic [7:0]  cmd_hdr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [47:0] rsp_word,
    input logic [47:0] timer_now
);

    logic fire, wr_op, known_op, data_out;

    assign fire     = cmd_valid && cmd_ready;
    assign wr_op    = (cmd_hdr >= 8'h40) && (cmd_hdr <= 8'h43);
    assign known_op = (cmd_hdr >= 8'h40) && (cmd_hdr <= 8'h49);
    assign data_out = rsp_valid && rsp_ready && (rsp_word[47:40] >= 8'h44)
                      && (rsp_word[47:40] <= 8'h49);

    // R1
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_hdr == 8'h40) |=> (timer_now == 48'd0));

    // R2
    a_r2_count: assert property (@(posedge clk) disable iff (rst)
        !(fire && wr_op) |=> (timer_now == $past(timer_now) + 48'd1));

    // R7
    a_r7_close: assert property (@(posedge clk) disable iff (rst)
        data_out |=> (rsp_valid && rsp_word[47:40] == 8'h71));

    // R9
    a_r9_bad: assert property (@(posedge clk) disable iff (rst)
        (fire && !known_op) |=> (rsp_valid && rsp_word[47:40] == 8'h73
                                 && rsp_word[39:32] == $past(cmd_hdr)));

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_word)));

endmodule

bind sc_cmd_timer sc_cmd_timer_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_hdr   (cmd_hdr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_word  (rsp_word),
    .timer_now (timer_now)
);

// File: tb/test_sc_cmd_timer.sv
module test_sc_cmd_timer;

    localparam logic [31:0] ID = 32'hC0DE_0A17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_hdr = 8'h00;
    logic [15:0] cmd_arg = 16'h0000;
    logic        shutter = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [47:0] rsp_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit ready_hi_mode = 1'b0;
    bit shutter_rand  = 1'b0;

    always #10 clk = ~clk;

    sc_cmd_timer #(.CHIP_ID(ID)) i_sc_cmd_timer (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_hdr   (cmd_hdr),
        .cmd_arg   (cmd_arg),
        .shutter   (shutter),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_word  (rsp_word)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [47:0] e);
        case (e[47:40])
            8'h70:        return (e[39:32] == 8'h40) ? "R1" : "R3/R8";
            8'h71:        return "R7";
            8'h73:        return "R9";
            8'h44, 8'h45: return "R2/R4";
            8'h46, 8'h47: return "R5";
            8'h48, 8'h49: return "R6";
            default:      return "R10";
        endcase
    endfunction

    function automatic logic [47:0] ctl(input logic [7:0] h, input logic [7:0] echo);
        return {h, echo, ID};
    endfunction

    // reference model built from the requirements
    logic [47:0] tm_m, rc_m, fc_m, nxt_m;
    logic        sd1, sd2, sd3;
    logic [47:0] expq[$];

    always @(posedge clk) begin
        if (rst) begin
            tm_m <= '0; rc_m <= '0; fc_m <= '0;
            sd1 <= 1'b0; sd2 <= 1'b0; sd3 <= 1'b0;
        end else begin
            sd1 <= shutter; sd2 <= sd1; sd3 <= sd2;
            if (sd2 && !sd3) rc_m <= tm_m;   // R5
            if (!sd2 && sd3) fc_m <= tm_m;   // R6
            nxt_m = tm_m + 48'd1;            // R2
            if (cmd_valid) begin
                case (cmd_hdr)
                    8'h40: begin nxt_m = '0; expq.push_back(ctl(8'h70, cmd_hdr)); end
                    8'h41: begin nxt_m = tm_m; nxt_m[15:0]  = cmd_arg; expq.push_back(ctl(8'h70, cmd_hdr)); end
                    8'h42: begin nxt_m = tm_m; nxt_m[31:16] = cmd_arg; expq.push_back(ctl(8'h70, cmd_hdr)); end
                    8'h43: begin nxt_m = tm_m; nxt_m[47:32] = cmd_arg; expq.push_back(ctl(8'h70, cmd_hdr)); end
                    8'h44: expq.push_back({cmd_hdr, 8'h00, tm_m[31:0]});
                    8'h45: expq.push_back({cmd_hdr, 24'h0, tm_m[47:32]});
                    8'h46: expq.push_back({cmd_hdr, 8'h00, rc_m[31:0]});
                    8'h47: expq.push_back({cmd_hdr, 24'h0, rc_m[47:32]});
                    8'h48: expq.push_back({cmd_hdr, 8'h00, fc_m[31:0]});
                    8'h49: expq.push_back({cmd_hdr, 24'h0, fc_m[47:32]});
                    default: expq.push_back(ctl(8'h73, cmd_hdr));
                endcase
                if (cmd_hdr >= 8'h40 && cmd_hdr <= 8'h49)
                    expq.push_back(ctl(8'h71, cmd_hdr));
            end
            tm_m <= nxt_m;
        end
    end

    // reply monitor: drive ready at negedge, sample 1 ns later
    logic        prev_v = 1'b0, prev_r = 1'b0;
    logic [47:0] prev_w = '0;
    initial begin
        forever begin
            @(negedge clk);
            rsp_ready = ready_hi_mode ? 1'b1 : (($urandom % 4) != 0);
            #1;
            if (!rst) begin
                if (prev_v && !prev_r) begin
                    check("R10 hold", {47'd0, rsp_valid}, 48'd1);
                    check("R10 hold", rsp_word, prev_w);
                end
                if (rsp_valid && rsp_ready) begin
                    if (expq.size() == 0) check("R10 extra", rsp_word, 48'hx);
                    else begin
                        logic [47:0] e;
                        e = expq.pop_front();
                        check(tag_of(e), rsp_word, e);
                    end
                end
            end
            prev_v = rsp_valid; prev_r = rsp_ready; prev_w = rsp_word;
        end
    end

    // random shutter activity
    initial begin
        forever begin
            @(negedge clk);
            if (shutter_rand && ($urandom % 6) == 0) shutter = ~shutter;
        end
    end

    task automatic send(input logic [7:0] h, input logic [15:0] a);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_hdr = h; cmd_arg = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && (expq.size() != 0 || rsp_valid); i++) @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        // R11 reset state
        check("R11 rsp_valid", {47'd0, rsp_valid}, 48'd0);
        check("R11 cmd_ready", {47'd0, cmd_ready}, 48'd1);
        send(8'h46, 16'h0);          // R11 capture reads zero
        send(8'h49, 16'h0);
        send(8'h44, 16'h0);
        // R3 and R2: load all ones, then wrap
        send(8'h41, 16'hFFFF);
        send(8'h42, 16'hFFFF);
        send(8'h43, 16'hFFFF);
        send(8'h45, 16'h0);
        send(8'h44, 16'h0);
        // R1 clear
        send(8'h40, 16'h1234);
        send(8'h44, 16'h0);
        // R5/R6 directed pulse
        @(negedge clk); shutter = 1'b1;
        repeat (5) @(negedge clk); shutter = 1'b0;
        repeat (5) @(negedge clk);
        send(8'h46, 16'h0); send(8'h47, 16'h0);
        send(8'h48, 16'h0); send(8'h49, 16'h0);
        // R9 unknown opcodes at range ends
        send(8'h00, 16'h0); send(8'hFF, 16'h0); send(8'h4A, 16'h0); send(8'h3F, 16'h0);
        send(8'h45, 16'h0);
        // one-cycle shutter glitch
        @(negedge clk); shutter = 1'b1; @(negedge clk); shutter = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h46, 16'h0); send(8'h48, 16'h0);
        drain();
        // random phase
        shutter_rand = 1'b1;
        for (int n = 0; n < 400; n++) begin
            int sel;
            logic [7:0]  h;
            logic [15:0] a;
            sel = $urandom % 13;
            a   = (($urandom % 5) == 0) ? 16'hFFFF : 16'($urandom);
            if (sel < 10)       h = 8'h40 + 8'(sel);
            else if (sel == 10) begin
                h = 8'($urandom);
                if (h >= 8'h40 && h <= 8'h49) h = 8'hA5;
            end else            h = 8'h44 + 8'(sel - 11);
            if (n == 200) ready_hi_mode = 1'b1;
            send(h, a);
        end
        shutter_rand = 1'b0;
        drain();
        check("R10 pending", 48'(expq.size()), 48'd0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule